// File: doc/BRIEF.md
# Self-Timed Page Write Controller for Byte-Alterable Nonvolatile Memory

This block is the control logic of a small nonvolatile byte store. A host drives an address, a data byte and three active-low strobes (select, write, output enable). A write command latches the address and byte on the clock edge where it is seen, and the host bus is free again on the following cycle. The block then runs the whole write on its own: it clears the target location, programs the new byte, and reads it back to confirm it, all timed by an internal cycle counter. The counter is sized from the clock frequency and the required write time.

Bytes that arrive close together and fall in the same page are gathered in a page buffer. They are all committed in one self-timed cycle, which makes the time per byte much shorter than for single-byte writes. While the cycle runs, a busy output is high, reads return a status byte instead of array data, and new writes are dropped. A programming fault that the read-back catches causes the program phase to be repeated a bounded number of times. When the retries run out, a sticky error flag is raised. A write counter for each page models limited endurance and raises a wear warning.

Top module: `nvm_page_writer`

## Requirements
- R1: A write command is any clock edge with `cs_n`=0, `we_n`=0 and `oe_n`=1. Its address and data are captured on that edge. Later changes on the bus do not alter the byte that gets committed.
- R2: A read is any clock edge with `cs_n`=0, `oe_n`=0 and `we_n`=1. When not busy, `rdata` shows the addressed byte after that edge. A location never programmed since reset reads all ones. On a cycle with no read, `rdata` is zero.
- R3: A commit first erases and then programs the loaded locations of the page, in that order. Locations in the page that were not loaded keep their old contents.
- R4: With PHASE = CLK_MHZ*CYCLE_US/2, a commit whose read-back passes keeps `busy` high for exactly 2*PHASE + PAGE_BYTES cycles.
- R5: While `busy` is high, a read returns a status byte: the MSB is the inverse of the MSB of the last accepted write byte, and all other bits are zero. Write commands are dropped and leave the array unchanged.
- R6: Writes to distinct offsets of one page are gathered. When every offset of the page is loaded, `busy` rises one cycle after the filling write, and one busy window commits all of the bytes.
- R7: If no byte is accepted for LOAD_TO cycles after the last accepted one, the commit starts: `busy` rises LOAD_TO cycles after that byte. During loading, a byte whose page differs from the first byte's page is rejected.
- R8: With `cs_n`=1 the bus is ignored: no write is taken and `rdata` stays zero. A commit already running completes normally.
- R9: With FAULT_MODEL=1, the cell at SLOW_ADDR stays erased until program attempt number SLOW_PULSES. Each failed read-back repeats the program phase, adding PHASE + PAGE_BYTES busy cycles. If a later attempt succeeds, `err` stays low.
- R10: With FAULT_MODEL=1, bit 0 of the cell at DEAD_ADDR is stuck at one. After MAX_RETRY repeats the commit ends, `err` rises and stays high until reset.
- R11: Each page counts its commits, saturating at ENDURANCE. `wear_warn` goes high once any page reaches ENDURANCE and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data or status byte |
| busy | output | 1 | High while a self-timed commit runs |
| err | output | 1 | Sticky read-back failure flag |
| wear_warn | output | 1 | Some page has reached its endurance limit |

## Verification
A sequencer that leaves a phase too early or too late shows up at once as a busy window of the wrong length. A wrong load-window count moves the busy onset by whole cycles, so both are measured to the exact cycle. A page buffer that keeps or loses a byte, or an erase mask that spills onto neighbours, appears in the first read-back after the window closes. A retry counter that is off by one changes the busy length by PHASE + PAGE_BYTES cycles and flips `err`. A wear count that is off shows as a `wear_warn` edge one commit early or late.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_ERASE,
      ST_PROG,
      ST_VERIFY
   } seq_state_t;

   // cycles per erase or program phase: half the total write time
   function automatic int unsigned phase_cycles(input int unsigned clk_mhz,
                                                input int unsigned span_us);
      return (clk_mhz * span_us) / 2;
   endfunction

endpackage

// File: rtl/nvm_phase_timer.sv
module nvm_phase_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/nvm_page_buf.sv
module nvm_page_buf #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_BYTES = 16,
   parameter int unsigned OFF_W      = $clog2(PAGE_BYTES)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 clr,
   input  logic                                 wr_en,
   input  logic [OFF_W-1:0]                     wr_off,
   input  logic [DATA_W-1:0]                    wr_data,
   output logic [PAGE_BYTES-1:0]                valid,
   output logic [PAGE_BYTES-1:0][DATA_W-1:0]    data,
   output logic                                 full
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= '0;
         data  <= '1;
      end else if (clr) begin
         valid <= '0;
      end else if (wr_en) begin
         valid[wr_off] <= 1'b1;
         data[wr_off]  <= wr_data;
      end
   end

   assign full = &valid;

   // loaded offsets stay loaded until the buffer is cleared
   assert_valid_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((valid & $past(valid)) == $past(valid)));

endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PAGE_BYTES  = 16,
   parameter int unsigned OFF_W       = 4,
   parameter int unsigned PG_W        = 4,
   parameter int unsigned TRY_W       = 2,
   parameter bit          FAULT_MODEL = 1'b0,
   parameter int unsigned SLOW_ADDR   = 0,
   parameter int unsigned SLOW_PULSES = 1,
   parameter int unsigned DEAD_ADDR   = 0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              erase_go,
   input  logic                              prog_go,
   input  logic [PG_W-1:0]                   page_sel,
   input  logic [PAGE_BYTES-1:0]             sel_mask,
   input  logic [PAGE_BYTES-1:0][DATA_W-1:0] data,
   input  logic [TRY_W-1:0]                  try_num,
   input  logic [ADDR_W-1:0]                 host_addr,
   input  logic [OFF_W-1:0]                  chk_off,
   output logic [DATA_W-1:0]                 host_q,
   output logic [DATA_W-1:0]                 chk_q
);

   localparam int unsigned DEPTH = 2 ** ADDR_W;

   logic [DATA_W-1:0] mem    [DEPTH];
   logic [DATA_W-1:0] shaped [PAGE_BYTES];

   // value each cell actually takes when programmed
   for (genvar gi = 0; gi < PAGE_BYTES; gi++) begin : g_cell
      logic [ADDR_W-1:0] cell_addr;
      assign cell_addr = {page_sel, OFF_W'(gi)};
      if (FAULT_MODEL) begin : g_fault
         logic is_dead, is_slow_early;
         assign is_dead       = (cell_addr == ADDR_W'(DEAD_ADDR));
         assign is_slow_early = (cell_addr == ADDR_W'(SLOW_ADDR)) &&
                                ((32'(try_num) + 32'd1) < SLOW_PULSES);
         assign shaped[gi] = is_dead       ? (data[gi] | DATA_W'(1)) :
                             is_slow_early ? {DATA_W{1'b1}}        :
                                             data[gi];
      end else begin : g_ideal
         assign shaped[gi] = data[gi];
      end
   end

   if (!FAULT_MODEL) begin : g_no_fault_use
      logic unused_try;
      assign unused_try = ^try_num;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (sel_mask[i]) begin
               if (erase_go)     mem[{page_sel, OFF_W'(i)}] <= '1;
               else if (prog_go) mem[{page_sel, OFF_W'(i)}] <= shaped[i];
            end
         end
      end
   end

   assign host_q = mem[host_addr];
   assign chk_q  = mem[{page_sel, chk_off}];

   // erase and program pulses never overlap
   assert_one_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(erase_go && prog_go));

endmodule

// File: rtl/nvm_wear_track.sv
module nvm_wear_track #(
   parameter int unsigned PAGES     = 16,
   parameter int unsigned PG_W      = 4,
   parameter int unsigned ENDURANCE = 100000,
   parameter int unsigned CNT_W     = $clog2(ENDURANCE + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bump,
   input  logic [PG_W-1:0] page,
   output logic            wear_warn
);

   logic [PAGES-1:0] sat;

   for (genvar gp = 0; gp < PAGES; gp++) begin : g_page
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (bump && page == PG_W'(gp) && cnt != CNT_W'(ENDURANCE))
            cnt <= cnt + 1'b1;
      end
      assign sat[gp] = (cnt == CNT_W'(ENDURANCE));

      assert_wear_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
         cnt <= CNT_W'(ENDURANCE));
      assert_wear_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
         sat[gp] |=> sat[gp]);
   end

   assign wear_warn = |sat;

endmodule

// File: rtl/nvm_page_writer.sv
module nvm_page_writer
   import nvm_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PAGE_BYTES  = 16,
   parameter int unsigned CLK_MHZ     = 100,
   parameter int unsigned CYCLE_US    = 2000,
   parameter int unsigned LOAD_TO     = 200,
   parameter int unsigned MAX_RETRY   = 3,
   parameter int unsigned ENDURANCE   = 100000,
   parameter bit          FAULT_MODEL = 1'b0,
   parameter int unsigned SLOW_ADDR   = 0,
   parameter int unsigned SLOW_PULSES = 1,
   parameter int unsigned DEAD_ADDR   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              busy,
   output logic              err,
   output logic              wear_warn
);

   localparam int unsigned OFF_W   = $clog2(PAGE_BYTES);
   localparam int unsigned PG_W    = ADDR_W - OFF_W;
   localparam int unsigned PAGES   = 2 ** PG_W;
   localparam int unsigned PHASE   = phase_cycles(CLK_MHZ, CYCLE_US);
   localparam int unsigned TMR_MAX = (PHASE > LOAD_TO) ? PHASE : LOAD_TO;
   localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
   localparam int unsigned TRY_W   = $clog2(MAX_RETRY + 1);

   // elaboration-time parameter checks
   if (DATA_W < 2) begin : g_chk_data
      $error("DATA_W must be at least 2");
   end
   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_chk_page
      $error("PAGE_BYTES must be a power of two, at least 2");
   end
   if (PAGE_BYTES >= 2 ** ADDR_W) begin : g_chk_span
      $error("PAGE_BYTES must be smaller than the array");
   end
   if (PHASE < 1 || LOAD_TO < 1) begin : g_chk_time
      $error("phase length and load window must be at least one cycle");
   end
   if (MAX_RETRY < 1 || ENDURANCE < 1) begin : g_chk_limits
      $error("MAX_RETRY and ENDURANCE must be at least 1");
   end

   seq_state_t state;

   logic                             wr_cmd, rd_cmd, accept;
   logic [PG_W-1:0]                  addr_page, cur_page;
   logic [OFF_W-1:0]                 addr_off, vidx;
   logic [TRY_W-1:0]                 tries;
   logic [TMR_W-1:0]                 tmr;
   logic                             tmr_clr;
   logic                             load_exit, erase_end, prog_end, vlast;
   logic                             chk_bad, any_bad, bad_acc, retry, finish;
   logic                             err_q, last_msb;
   logic [DATA_W-1:0]                rdata_q, host_q, chk_q;
   logic [PAGE_BYTES-1:0]            buf_valid;
   logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_data;
   logic                             buf_full;

   // bus decode
   assign wr_cmd    = !cs_n && !we_n && oe_n;
   assign rd_cmd    = !cs_n && !oe_n && we_n;
   assign addr_page = addr[ADDR_W-1:OFF_W];
   assign addr_off  = addr[OFF_W-1:0];
   assign busy      = (state == ST_ERASE) || (state == ST_PROG) || (state == ST_VERIFY);

   assign accept = wr_cmd &&
                   ((state == ST_IDLE) ||
                    (state == ST_LOAD && !buf_full && addr_page == cur_page));

   // phase events
   assign load_exit = (state == ST_LOAD) && !accept &&
                      (buf_full || tmr == TMR_W'(LOAD_TO - 1));
   assign erase_end = (state == ST_ERASE) && (tmr == TMR_W'(PHASE - 1));
   assign prog_end  = (state == ST_PROG)  && (tmr == TMR_W'(PHASE - 1));
   assign vlast     = (state == ST_VERIFY) && (vidx == OFF_W'(PAGE_BYTES - 1));
   assign chk_bad   = (state == ST_VERIFY) && buf_valid[vidx] && (chk_q != buf_data[vidx]);
   assign any_bad   = bad_acc || chk_bad;
   assign retry     = vlast && any_bad && (tries != TRY_W'(MAX_RETRY));
   assign finish    = vlast && !retry;

   assign tmr_clr = accept || load_exit || erase_end || prog_end ||
                    (state == ST_VERIFY) || (state == ST_IDLE);

   nvm_phase_timer #(.CNT_W(TMR_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .cnt   (tmr)
   );

   nvm_page_buf #(
      .DATA_W     (DATA_W),
      .PAGE_BYTES (PAGE_BYTES),
      .OFF_W      (OFF_W)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (finish),
      .wr_en   (accept),
      .wr_off  (addr_off),
      .wr_data (wdata),
      .valid   (buf_valid),
      .data    (buf_data),
      .full    (buf_full)
   );

   nvm_cell_array #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .PAGE_BYTES  (PAGE_BYTES),
      .OFF_W       (OFF_W),
      .PG_W        (PG_W),
      .TRY_W       (TRY_W),
      .FAULT_MODEL (FAULT_MODEL),
      .SLOW_ADDR   (SLOW_ADDR),
      .SLOW_PULSES (SLOW_PULSES),
      .DEAD_ADDR   (DEAD_ADDR)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .erase_go  (erase_end),
      .prog_go   (prog_end),
      .page_sel  (cur_page),
      .sel_mask  (buf_valid),
      .data      (buf_data),
      .try_num   (tries),
      .host_addr (addr),
      .chk_off   (vidx),
      .host_q    (host_q),
      .chk_q     (chk_q)
   );

   nvm_wear_track #(
      .PAGES     (PAGES),
      .PG_W      (PG_W),
      .ENDURANCE (ENDURANCE)
   ) u_wear (
      .clk       (clk),
      .rst_n     (rst_n),
      .bump      (finish),
      .page      (cur_page),
      .wear_warn (wear_warn)
   );

   // sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cur_page <= '0;
         tries    <= '0;
         vidx     <= '0;
         bad_acc  <= 1'b0;
         err_q    <= 1'b0;
         last_msb <= 1'b0;
      end else begin
         if (accept) last_msb <= wdata[DATA_W-1];
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  state    <= ST_LOAD;
                  cur_page <= addr_page;
                  tries    <= '0;
               end
            end
            ST_LOAD: begin
               if (load_exit) state <= ST_ERASE;
            end
            ST_ERASE: begin
               if (erase_end) state <= ST_PROG;
            end
            ST_PROG: begin
               if (prog_end) begin
                  state   <= ST_VERIFY;
                  vidx    <= '0;
                  bad_acc <= 1'b0;
               end
            end
            ST_VERIFY: begin
               vidx    <= vidx + 1'b1;
               bad_acc <= any_bad;
               if (retry) begin
                  state <= ST_PROG;
                  tries <= tries + 1'b1;
               end else if (finish) begin
                  state <= ST_IDLE;
                  if (any_bad) err_q <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // read port: status while busy, array otherwise, zero when idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (rd_cmd)
         rdata_q <= busy ? {~last_msb, {(DATA_W-1){1'b0}}} : host_q;
      else
         rdata_q <= '0;
   end

   assign rdata = rdata_q;
   assign err   = err_q;

   assert_erase_then_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PROG && $past(state) != ST_PROG) |->
         ($past(state) == ST_ERASE || $past(state) == ST_VERIFY));

   assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ERASE || state == ST_PROG) |-> (tmr < TMR_W'(PHASE)));

   assert_buf_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !finish) |=> $stable(buf_valid));

   assert_status_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd && busy) |=> (rdata[DATA_W-1] != $past(last_msb)));

   assert_retry_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tries <= TRY_W'(MAX_RETRY));

   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

endmodule

// File: tb/tb_nvm_page_writer.sv
module tb_nvm_page_writer;

   localparam int AW    = 5;
   localparam int DW    = 8;
   localparam int PB    = 4;
   localparam int PH    = 8;     // 1 MHz * 16 us / 2
   localparam int LTO   = 6;
   localparam int RETRY = 2;
   localparam int SLOW  = 9;
   localparam int DEAD  = 30;
   localparam int BASE_LEN = 2 * PH + PB;
   localparam int RETRY_LEN = PH + PB;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          busy, err, wear_warn;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   nvm_page_writer #(
      .ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .CLK_MHZ(1), .CYCLE_US(16),
      .LOAD_TO(LTO), .MAX_RETRY(RETRY), .ENDURANCE(3), .FAULT_MODEL(1'b1),
      .SLOW_ADDR(SLOW), .SLOW_PULSES(2), .DEAD_ADDR(DEAD)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy), .err(err),
      .wear_warn(wear_warn)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_idle();
      cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input int a, input int d);
      cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
      addr = AW'(a); wdata = DW'(d);
      @(posedge clk); @(negedge clk);
      bus_idle();
      addr = ~addr; wdata = ~wdata;   // host moves on at once
   endtask

   task automatic rd(input int a, output logic [DW-1:0] q);
      cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = AW'(a);
      @(posedge clk); @(negedge clk);
      q = rdata;
      bus_idle();
   endtask

   task automatic rd_check(input string tag, input int a, input int exp);
      logic [DW-1:0] q;
      rd(a, q);
      check(tag, 32'(q), 32'(exp));
   endtask

   task automatic wait_busy(input logic lvl);
      int g = 0;
      while (busy !== lvl && g < 500) begin @(negedge clk); g++; end
   endtask

   // measure cycles to busy onset and busy length
   task automatic expect_commit(input string tag, input int gap, input int len);
      int i = 0;
      int n = 0;
      while (busy !== 1'b1 && i < gap + 8) begin @(negedge clk); i++; end
      check({tag, " busy onset"}, 32'(i), 32'(gap));
      while (busy === 1'b1 && n < 500) begin @(negedge clk); n++; end
      check({tag, " busy length"}, 32'(n), 32'(len));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [DW-1:0] q;
      repeat (3) @(negedge clk);
      check("R2 reset rdata", 32'(rdata), 0);
      check("R4 reset busy", 32'(busy), 0);
      check("R10 reset err", 32'(err), 0);
      check("R11 reset wear_warn", 32'(wear_warn), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: erased value and zero output when not reading
      rd_check("R2 unprogrammed read", 3, 8'hFF);
      @(negedge clk);
      check("R2 no read gives zero", 32'(rdata), 0);

      // R1 R4 R7: single byte, bus changed right after the command
      wr(3, 8'h5A);
      expect_commit("R7 R4 byte write", LTO, BASE_LEN);
      rd_check("R1 captured byte", 3, 8'h5A);
      rd_check("R3 neighbour untouched", 2, 8'hFF);

      // R6 R7: page fill with one foreign-page byte rejected
      wr(4, 8'hA0);
      wr(5, 8'hA1);
      wr(12, 8'hC3);
      wr(6, 8'hA2);
      wr(7, 8'hA3);
      expect_commit("R6 full page", 1, BASE_LEN);
      for (int k = 0; k < PB; k++) rd_check("R6 page byte", 4 + k, 8'hA0 + k);
      rd_check("R7 foreign page byte rejected", 12, 8'hFF);
      check("R11 warn after one commit", 32'(wear_warn), 0);

      // R5: status reads and dropped writes during busy
      wr(16, 8'h80);
      wait_busy(1'b1);
      rd_check("R5 status msb set data", 16, 8'h00);
      wr(17, 8'h33);
      check("R5 still busy", 32'(busy), 1);
      wait_busy(1'b0);
      rd_check("R5 write during busy dropped", 17, 8'hFF);
      rd_check("R5 committed byte", 16, 8'h80);
      wr(20, 8'h12);
      wait_busy(1'b1);
      rd_check("R5 status msb clear data", 20, 8'h80);
      wait_busy(1'b0);
      rd_check("R5 second byte", 20, 8'h12);

      // R8: deselected bus ignored
      cs_n = 1'b1; we_n = 1'b0; oe_n = 1'b1; addr = 5'd24; wdata = 8'h55;
      repeat (3) @(negedge clk);
      oe_n = 1'b0; we_n = 1'b1;
      @(negedge clk);
      check("R8 deselected read zero", 32'(rdata), 0);
      bus_idle();
      repeat (LTO + 2) @(negedge clk);
      check("R8 no commit while deselected", 32'(busy), 0);
      rd_check("R8 deselected write ignored", 24, 8'hFF);
      // running commit completes while deselected strobes toggle
      wr(25, 8'h44);
      wait_busy(1'b1);
      we_n = 1'b0;
      repeat (4) @(negedge clk);
      we_n = 1'b1;
      wait_busy(1'b0);
      rd_check("R8 commit completed", 25, 8'h44);

      // R9: slow cell needs one retry
      wr(SLOW, 8'h3C);
      expect_commit("R9 slow cell", LTO, BASE_LEN + RETRY_LEN);
      check("R9 err stays low", 32'(err), 0);
      rd_check("R9 slow cell value", SLOW, 8'h3C);

      // R11: page 1 reaches three commits
      wr(5, 8'h11);
      expect_commit("R11 second commit", LTO, BASE_LEN);
      check("R11 warn below limit", 32'(wear_warn), 0);
      wr(6, 8'h22);
      expect_commit("R11 third commit", LTO, BASE_LEN);
      check("R11 warn at limit", 32'(wear_warn), 1);
      rd_check("R3 page neighbour kept", 4, 8'hA0);
      rd_check("R3 page neighbour kept", 7, 8'hA3);
      rd_check("R11 rewritten byte", 6, 8'h22);

      // R10: stuck bit exhausts retries
      wr(DEAD, 8'h00);
      expect_commit("R10 dead cell", LTO, BASE_LEN + RETRY * RETRY_LEN);
      check("R10 err raised", 32'(err), 1);
      rd_check("R10 stuck value", DEAD, 8'h01);
      wr(28, 8'h77);
      expect_commit("R10 later write", LTO, BASE_LEN);
      check("R10 err sticky", 32'(err), 1);
      rd_check("R10 later byte", 28, 8'h77);
      check("R11 warn sticky", 32'(wear_warn), 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule